// File: doc/BRIEF.md
# Level-Based Interrupt Controller with Wakeup

This block sits between a group of peripheral request lines and a small processor core. Each peripheral source gets a 3-bit priority level, which software programs through 16-bit setup words that hold two sources each. On every cycle the controller finds the strongest pending source. If the core can take that source, given its interrupt enable and current interrupt level, the controller latches the vector number, the level and the vector address into a presentation slot. The slot holds that request until the core acknowledges it.

Two other requests share the slot. A watchdog non-maskable request always uses vector 2, always wins, and ignores the core's enable and level. A software request, raised by the core when it runs an interrupt instruction, names any vector from 0 to 31 and may carry a level for the core to load.

The block also decides when the core leaves halt or sleep. Any pending source, the watchdog request, a debug request or reset wakes the core, whatever the level settings are. A second flag tells the core whether to enter a handler at once or to carry on after the halt instruction.

Top module: `lvl_intc`

## Requirements
- R1: A rising edge on `nmi_req` loads the free slot with vector 2, `irq_nmi`=1, `irq_lvl_ld`=0 and `irq_vaddr` = `vtbl_base`+8. This happens whatever `cpu_ie` and `cpu_lvl` are, and ahead of any pending software or source request.
- R2: Setup word k holds the level of source 2k in bits [2:0] and the level of source 2k+1 in bits [10:8]. `cfg_rdata` shows word `cfg_idx` with no added delay, every other bit reads 0, and written values in those other bits have no effect. All levels reset to 0.
- R3: A source request is taken only when `cpu_ie`=1 and its level is strictly greater than `cpu_lvl`, so a level-0 source is never taken.
- R4: Among requesting sources the highest level wins, and a tie goes to the lowest source index. Source i is presented as vector 4+i with `irq_hw`=1, `irq_lvl_ld`=1 and `irq_lvl` set to its level.
- R5: The slot loads on the clock edge at which its inputs qualify. It then keeps its vector, level and kind until `irq_ack`. The edge that samples `irq_ack` clears `irq_valid`, and the earliest edge at which a new request can load is the one after that.
- R6: A one-cycle `swi_req` presents `swi_vec` whatever `cpu_ie` and `cpu_lvl` are. It ranks below the non-maskable request and above source requests, and it carries `irq_lvl_ld`=`swi_lvl_en` with `irq_lvl`=`swi_lvl`.
- R7: `wake` rises one cycle after `cpu_asleep` is seen together with any source request (whatever its level, `cpu_ie` or `cpu_lvl`), `nmi_req` or `dbg_req`. `wake` is high while reset is held and is low when `cpu_asleep`=0.
- R8: `wake_isr` rises with `wake` only when the cause is `nmi_req` or a source request the core can take under R3. A debug request, or a source it cannot take, gives `wake` without `wake_isr`.
- R9: `irq_vaddr` equals `vtbl_base` plus 4 times `irq_vec`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_req | input | NUM_SRC | Peripheral request lines, one per source |
| cfg_we | input | 1 | Write strobe for a setup word |
| cfg_idx | input | IDX_W | Setup word index |
| cfg_wdata | input | 16 | Setup word write data |
| cfg_rdata | output | 16 | Setup word read data for `cfg_idx` |
| nmi_req | input | 1 | Watchdog non-maskable request |
| swi_req | input | 1 | One-cycle software interrupt strobe |
| swi_vec | input | 5 | Software interrupt vector number |
| swi_lvl_en | input | 1 | Software interrupt carries a level |
| swi_lvl | input | 3 | Level for the software interrupt |
| dbg_req | input | 1 | Debug interrupt (wake only) |
| cpu_ie | input | 1 | Core interrupt enable |
| cpu_lvl | input | 3 | Core current interrupt level |
| cpu_asleep | input | 1 | Core is in halt or sleep |
| vtbl_base | input | ADDR_W | Vector table base address |
| irq_ack | input | 1 | Core accepts the presented request |
| irq_valid | output | 1 | Slot holds a request |
| irq_vec | output | 5 | Presented vector number |
| irq_lvl | output | 3 | Presented level |
| irq_lvl_ld | output | 1 | Core should load `irq_lvl` into its level field |
| irq_nmi | output | 1 | Presented request is non-maskable |
| irq_hw | output | 1 | Presented request comes from a peripheral source |
| irq_vaddr | output | ADDR_W | Vector address of the presented request |
| wake | output | 1 | Leave halt or sleep |
| wake_isr | output | 1 | After waking, go straight to the handler |

## Verification
The slot and both wake flags are registered. Each result is therefore due exactly one rising edge after the stimulus that causes it, and the bench drives on the falling edge and samples on the next falling edge. After an acknowledge the bench first checks one cycle of an empty slot and then the reload on the following edge, so the one-cycle gap of R5 is checked as a cycle count. The setup word read path has no register, and the bench samples it in the same cycle it sets the index.

// File: rtl/intc_pkg.sv
// Package: shared widths and constants for the level-based interrupt controller.
// Assumes the core uses 3-bit levels, 5-bit vector numbers and 4-byte vector entries.
package intc_pkg;
    localparam int LVL_W     = 3;
    localparam int VEC_W     = 5;
    localparam int WORD_W    = 16;
    localparam int VEC_BYTES = 4;
    localparam int HI_LSB    = 8;

    typedef logic [LVL_W-1:0] lvl_t;
    typedef logic [VEC_W-1:0] vec_t;

    localparam vec_t NMI_VEC = 5'd2;
endpackage

// File: rtl/intc_lvl_regs.sv
// Module: level setup words. Each 16-bit word holds two 3-bit source levels,
// the even source in [2:0] and the odd source in [10:8]. All other bits read 0.
// Assumes a single write port and a combinational read port on the same index.
module intc_lvl_regs
    import intc_pkg::*;
#(
    parameter int NUM_SRC  = 8,
    parameter int NUM_REGS = (NUM_SRC + 1) / 2,
    parameter int IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output lvl_t              lvl_o [NUM_SRC]
);
    localparam int SLOTS = 2 * NUM_REGS;

    lvl_t lvl_pad [SLOTS];
    logic unused_wbits;

    assign unused_wbits = ^{wdata[WORD_W-1:HI_LSB+LVL_W], wdata[HI_LSB-1:LVL_W]};

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        if (s < NUM_SRC) begin : g_real
            lvl_t lvl_q;
            // Capture this source's level field when its word is written.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    lvl_q <= '0;
                end else if (we && idx == IDX_W'(s / 2)) begin
                    if (s % 2 == 0) lvl_q <= wdata[LVL_W-1:0];
                    else            lvl_q <= wdata[HI_LSB+LVL_W-1:HI_LSB];
                end
            end
            assign lvl_pad[s] = lvl_q;
            assign lvl_o[s]   = lvl_q;
        end else begin : g_pad
            assign lvl_pad[s] = '0;
        end
    end

    // Assemble the addressed word with reserved bits held at 0.
    always_comb begin
        rdata = '0;
        for (int k = 0; k < NUM_REGS; k++) begin
            if (idx == IDX_W'(k)) begin
                rdata[LVL_W-1:0]               = lvl_pad[2*k];
                rdata[HI_LSB+LVL_W-1:HI_LSB]   = lvl_pad[2*k+1];
            end
        end
    end
endmodule

// File: rtl/intc_arbiter.sv
// Module: source arbiter. Finds the requesting source with the highest level,
// with ties going to the lowest index. Purely combinational.
// Assumes the request lines are already synchronous to the block clock.
module intc_arbiter
    import intc_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int SIDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0] req,
    input  lvl_t               lvl [NUM_SRC],
    output logic               any,
    output logic [SIDX_W-1:0]  win_idx,
    output lvl_t               win_lvl
);
    // Scan from the top index down so that a later equal level replaces the winner.
    always_comb begin
        any     = 1'b0;
        win_idx = '0;
        win_lvl = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req[i] && (!any || lvl[i] >= win_lvl)) begin
                any     = 1'b1;
                win_idx = SIDX_W'(i);
                win_lvl = lvl[i];
            end
        end
    end
endmodule

// File: rtl/intc_wake.sv
// Module: halt/sleep exit logic. Registers the wake request and whether the core
// should branch to a handler straight away. Level settings never block wake.
// Assumes reset itself also counts as a wake cause.
module intc_wake (
    input  logic clk,
    input  logic rst_n,
    input  logic asleep,
    input  logic src_any,
    input  logic nmi_req,
    input  logic dbg_req,
    input  logic can_take,
    output logic wake,
    output logic wake_isr
);
    logic cause;

    assign cause = asleep && (src_any || nmi_req || dbg_req);

    // Register the wake decision and the branch-to-handler flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake     <= 1'b1;
            wake_isr <= 1'b0;
        end else begin
            wake     <= cause;
            wake_isr <= cause && (nmi_req || can_take);
        end
    end
endmodule

// File: rtl/lvl_intc.sv
// Module: top of the level-based interrupt controller. Holds the presentation
// slot and the pending latches for the non-maskable and software requests, and
// wires the setup words, the arbiter and the wake logic.
// Assumes the core drives irq_ack for one cycle per accepted request.
module lvl_intc
    import intc_pkg::*;
#(
    parameter int NUM_SRC      = 8,
    parameter int SRC_VEC_BASE = 4,
    parameter int ADDR_W       = 24,
    parameter int NUM_REGS     = (NUM_SRC + 1) / 2,
    parameter int IDX_W        = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SRC-1:0]  src_req,
    input  logic                cfg_we,
    input  logic [IDX_W-1:0]    cfg_idx,
    input  logic [15:0]         cfg_wdata,
    output logic [15:0]         cfg_rdata,
    input  logic                nmi_req,
    input  logic                swi_req,
    input  logic [4:0]          swi_vec,
    input  logic                swi_lvl_en,
    input  logic [2:0]          swi_lvl,
    input  logic                dbg_req,
    input  logic                cpu_ie,
    input  logic [2:0]          cpu_lvl,
    input  logic                cpu_asleep,
    input  logic [ADDR_W-1:0]   vtbl_base,
    input  logic                irq_ack,
    output logic                irq_valid,
    output logic [4:0]          irq_vec,
    output logic [2:0]          irq_lvl,
    output logic                irq_lvl_ld,
    output logic                irq_nmi,
    output logic                irq_hw,
    output logic [ADDR_W-1:0]   irq_vaddr,
    output logic                wake,
    output logic                wake_isr
);
    localparam int SIDX_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam int VEC_SHIFT = $clog2(VEC_BYTES);

    lvl_t              src_lvl [NUM_SRC];
    logic              win_any;
    logic [SIDX_W-1:0] win_idx;
    lvl_t              win_lvl;
    logic              hw_take;

    logic nmi_q, nmi_pend, nmi_rise, nmi_cand;
    logic swi_pend, swi_cand, swi_en_q, swi_en_sel;
    vec_t swi_vec_q, swi_vec_sel;
    lvl_t swi_lvl_q, swi_lvl_sel;
    logic load_nmi, load_swi, load_hw;

    u_regs_t_dummy_guard: assert final (SRC_VEC_BASE + NUM_SRC <= 32);

    intc_lvl_regs #(.NUM_SRC(NUM_SRC), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .idx   (cfg_idx),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .lvl_o (src_lvl)
    );

    intc_arbiter #(.NUM_SRC(NUM_SRC), .SIDX_W(SIDX_W)) u_arb (
        .req     (src_req),
        .lvl     (src_lvl),
        .any     (win_any),
        .win_idx (win_idx),
        .win_lvl (win_lvl)
    );

    assign hw_take = win_any && cpu_ie && (win_lvl > cpu_lvl);

    intc_wake u_wake (
        .clk      (clk),
        .rst_n    (rst_n),
        .asleep   (cpu_asleep),
        .src_any  (|src_req),
        .nmi_req  (nmi_req),
        .dbg_req  (dbg_req),
        .can_take (hw_take),
        .wake     (wake),
        .wake_isr (wake_isr)
    );

    assign nmi_rise    = nmi_req && !nmi_q;
    assign nmi_cand    = nmi_pend || nmi_rise;
    assign swi_cand    = swi_pend || swi_req;
    assign swi_vec_sel = swi_pend ? swi_vec_q : swi_vec;
    assign swi_lvl_sel = swi_pend ? swi_lvl_q : swi_lvl;
    assign swi_en_sel  = swi_pend ? swi_en_q  : swi_lvl_en;

    assign load_nmi = !irq_valid && nmi_cand;
    assign load_swi = !irq_valid && !nmi_cand && swi_cand;
    assign load_hw  = !irq_valid && !nmi_cand && !swi_cand && hw_take;

    // Detect watchdog edges and keep one non-maskable request until it is presented.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_q    <= 1'b0;
            nmi_pend <= 1'b0;
        end else begin
            nmi_q <= nmi_req;
            if (load_nmi)      nmi_pend <= 1'b0;
            else if (nmi_rise) nmi_pend <= 1'b1;
        end
    end

    // Hold a software request and its operands until the slot takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            swi_pend  <= 1'b0;
            swi_vec_q <= '0;
            swi_lvl_q <= '0;
            swi_en_q  <= 1'b0;
        end else if (load_swi) begin
            swi_pend <= 1'b0;
        end else if (swi_req && !swi_pend) begin
            swi_pend  <= 1'b1;
            swi_vec_q <= swi_vec;
            swi_lvl_q <= swi_lvl;
            swi_en_q  <= swi_lvl_en;
        end
    end

    // Presentation slot: load the winner when free, clear on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_valid  <= 1'b0;
            irq_vec    <= '0;
            irq_lvl    <= '0;
            irq_lvl_ld <= 1'b0;
            irq_nmi    <= 1'b0;
            irq_hw     <= 1'b0;
        end else if (irq_valid) begin
            if (irq_ack) irq_valid <= 1'b0;
        end else if (load_nmi) begin
            irq_valid  <= 1'b1;
            irq_vec    <= NMI_VEC;
            irq_lvl    <= '0;
            irq_lvl_ld <= 1'b0;
            irq_nmi    <= 1'b1;
            irq_hw     <= 1'b0;
        end else if (load_swi) begin
            irq_valid  <= 1'b1;
            irq_vec    <= swi_vec_sel;
            irq_lvl    <= swi_lvl_sel;
            irq_lvl_ld <= swi_en_sel;
            irq_nmi    <= 1'b0;
            irq_hw     <= 1'b0;
        end else if (load_hw) begin
            irq_valid  <= 1'b1;
            irq_vec    <= VEC_W'(SRC_VEC_BASE) + VEC_W'(win_idx);
            irq_lvl    <= win_lvl;
            irq_lvl_ld <= 1'b1;
            irq_nmi    <= 1'b0;
            irq_hw     <= 1'b1;
        end
    end

    assign irq_vaddr = vtbl_base + (ADDR_W'(irq_vec) << VEC_SHIFT);
endmodule

// File: rtl/intc_chk.sv
// Module: property checker for lvl_intc, attached through bind below.
// Assumes the same synchronous active-low reset as the design.
module intc_chk #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic [15:0]       cfg_rdata,
    input logic              cpu_ie,
    input logic [2:0]        cpu_lvl,
    input logic [ADDR_W-1:0] vtbl_base,
    input logic              irq_ack,
    input logic              irq_valid,
    input logic [4:0]        irq_vec,
    input logic [2:0]        irq_lvl,
    input logic              irq_lvl_ld,
    input logic              irq_nmi,
    input logic              irq_hw,
    input logic [ADDR_W-1:0] irq_vaddr,
    input logic              wake,
    input logic              wake_isr
);
    AST_NMI_FIXED_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid && irq_nmi |-> irq_vec == 5'd2 && irq_vaddr == vtbl_base + ADDR_W'(8) && !irq_lvl_ld); // R1
    AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata & 16'hF8F8) == 16'h0000); // R2
    AST_HW_ACCEPT_RULE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_valid) && irq_hw |-> $past(cpu_ie) && irq_lvl > $past(cpu_lvl)); // R3
    AST_HW_LEVEL_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid && irq_hw |-> irq_lvl != 3'd0 && irq_lvl_ld && !irq_nmi); // R4
    AST_SLOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid && !irq_ack |=> irq_valid && $stable(irq_vec) && $stable(irq_lvl) && $stable(irq_nmi) && $stable(irq_hw)); // R5
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid && irq_ack |=> !irq_valid); // R5
    AST_ISR_NEEDS_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_isr |-> wake); // R8
endmodule

bind lvl_intc intc_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_rdata  (cfg_rdata),
    .cpu_ie     (cpu_ie),
    .cpu_lvl    (cpu_lvl),
    .vtbl_base  (vtbl_base),
    .irq_ack    (irq_ack),
    .irq_valid  (irq_valid),
    .irq_vec    (irq_vec),
    .irq_lvl    (irq_lvl),
    .irq_lvl_ld (irq_lvl_ld),
    .irq_nmi    (irq_nmi),
    .irq_hw     (irq_hw),
    .irq_vaddr  (irq_vaddr),
    .wake       (wake),
    .wake_isr   (wake_isr)
);

// File: tb/tb_lvl_intc.sv
// Bench: table of arbitration vectors, then directed tests for reset, the
// setup words, request priority, slot holding and wake behaviour.
module tb_lvl_intc;
    localparam int NUM_SRC = 8;
    localparam int ADDR_W  = 24;

    logic               clk = 1'b0;
    logic               rst_n;
    logic [NUM_SRC-1:0] src_req;
    logic               cfg_we;
    logic [1:0]         cfg_idx;
    logic [15:0]        cfg_wdata, cfg_rdata;
    logic               nmi_req, swi_req, swi_lvl_en, dbg_req;
    logic [4:0]         swi_vec;
    logic [2:0]         swi_lvl, cpu_lvl;
    logic               cpu_ie, cpu_asleep, irq_ack;
    logic [ADDR_W-1:0]  vtbl_base;
    logic               irq_valid, irq_lvl_ld, irq_nmi, irq_hw, wake, wake_isr;
    logic [4:0]         irq_vec;
    logic [2:0]         irq_lvl;
    logic [ADDR_W-1:0]  irq_vaddr;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    lvl_intc #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .src_req(src_req),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .nmi_req(nmi_req), .swi_req(swi_req), .swi_vec(swi_vec),
        .swi_lvl_en(swi_lvl_en), .swi_lvl(swi_lvl), .dbg_req(dbg_req),
        .cpu_ie(cpu_ie), .cpu_lvl(cpu_lvl), .cpu_asleep(cpu_asleep),
        .vtbl_base(vtbl_base), .irq_ack(irq_ack),
        .irq_valid(irq_valid), .irq_vec(irq_vec), .irq_lvl(irq_lvl),
        .irq_lvl_ld(irq_lvl_ld), .irq_nmi(irq_nmi), .irq_hw(irq_hw),
        .irq_vaddr(irq_vaddr), .wake(wake), .wake_isr(wake_isr)
    );

    // Levels used by the table: src0=3 src1=5 src2=5 src3=0 src4=7 src5=1 src6=2 src7=7
    typedef struct packed {
        logic [7:0] req;
        logic       ie;
        logic [2:0] cl;
        logic       ev;
        logic [4:0] evec;
        logic [2:0] elvl;
    } vec_row_t;

    localparam int NROWS = 10;
    localparam vec_row_t TAB [NROWS] = '{
        '{8'h01, 1'b1, 3'd0, 1'b1, 5'd4,  3'd3},  // R4 single source
        '{8'h06, 1'b1, 3'd0, 1'b1, 5'd5,  3'd5},  // R4 tie, lowest index
        '{8'h90, 1'b1, 3'd0, 1'b1, 5'd8,  3'd7},  // R4 tie at top level
        '{8'h08, 1'b1, 3'd0, 1'b0, 5'd0,  3'd0},  // R3 level 0 never taken
        '{8'h01, 1'b1, 3'd3, 1'b0, 5'd0,  3'd0},  // R3 equal level refused
        '{8'h01, 1'b1, 3'd2, 1'b1, 5'd4,  3'd3},  // R3 strictly greater
        '{8'hFF, 1'b0, 3'd0, 1'b0, 5'd0,  3'd0},  // R3 disabled
        '{8'h21, 1'b1, 3'd2, 1'b1, 5'd4,  3'd3},  // R4 higher level wins
        '{8'h82, 1'b1, 3'd6, 1'b1, 5'd11, 3'd7},  // R3 only top passes
        '{8'h60, 1'b1, 3'd0, 1'b1, 5'd10, 3'd2}   // R4 higher of two lows
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] idx, input logic [15:0] d);
        cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = d;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic rd_check(input logic [1:0] idx, input logic [15:0] exp);
        cfg_idx = idx;
        #1;
        check("R2", "setup word readback", 32'(cfg_rdata), 32'(exp));
    endtask

    task automatic clear_slot();
        src_req = '0;
        for (int k = 0; k < 8 && irq_valid; k++) begin
            irq_ack = 1'b1;
            tick();
            irq_ack = 1'b0;
            tick();
        end
    endtask

    task automatic ack_once();
        irq_ack = 1'b1;
        tick();
        irq_ack = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        rst_n = 1'b0; src_req = '0; cfg_we = 1'b0; cfg_idx = '0; cfg_wdata = '0;
        nmi_req = 1'b0; swi_req = 1'b0; swi_vec = '0; swi_lvl_en = 1'b0; swi_lvl = '0;
        dbg_req = 1'b0; cpu_ie = 1'b0; cpu_lvl = '0; cpu_asleep = 1'b0;
        vtbl_base = 24'h008000; irq_ack = 1'b0;
        repeat (3) tick();

        // Reset state
        check("R5", "valid in reset", 32'(irq_valid), 0);
        check("R7", "wake in reset", 32'(wake), 1);
        check("R8", "wake_isr in reset", 32'(wake_isr), 0);
        rd_check(2'd0, 16'h0000);
        rst_n = 1'b1;
        tick();
        check("R7", "wake while awake", 32'(wake), 0);

        // Setup words
        wr(2'd0, 16'h0503);
        wr(2'd1, 16'h0005);
        wr(2'd2, 16'hF9FF);
        wr(2'd3, 16'h0702);
        rd_check(2'd0, 16'h0503);
        rd_check(2'd1, 16'h0005);
        rd_check(2'd2, 16'h0107);
        rd_check(2'd3, 16'h0702);

        // Arbitration table
        for (int r = 0; r < NROWS; r++) begin
            src_req = TAB[r].req; cpu_ie = TAB[r].ie; cpu_lvl = TAB[r].cl;
            tick();
            check(TAB[r].ev ? "R4" : "R3", $sformatf("row %0d valid", r), 32'(irq_valid), 32'(TAB[r].ev));
            if (TAB[r].ev) begin
                check("R4", $sformatf("row %0d vector", r), 32'(irq_vec), 32'(TAB[r].evec));
                check("R4", $sformatf("row %0d level", r), 32'(irq_lvl), 32'(TAB[r].elvl));
                check("R4", $sformatf("row %0d hw/ld", r), {30'd0, irq_hw, irq_lvl_ld}, 32'h3);
                check("R9", $sformatf("row %0d vaddr", r), 32'(irq_vaddr),
                      32'(vtbl_base) + 32'(TAB[r].evec) * 4);
            end
            clear_slot();
        end

        // Priority chain: non-maskable, then software, then source
        cpu_ie = 1'b1; cpu_lvl = 3'd0; src_req = 8'h10;
        nmi_req = 1'b1; swi_req = 1'b1; swi_vec = 5'd17; swi_lvl_en = 1'b1; swi_lvl = 3'd6;
        tick();
        nmi_req = 1'b0; swi_req = 1'b0;
        check("R1", "nmi valid", 32'(irq_valid), 1);
        check("R1", "nmi vector", 32'(irq_vec), 2);
        check("R1", "nmi flag/ld", {30'd0, irq_nmi, irq_lvl_ld}, 32'h2);
        check("R1", "nmi vaddr", 32'(irq_vaddr), 32'h008008);
        ack_once();
        check("R5", "gap after ack", 32'(irq_valid), 0);
        tick();
        check("R6", "swi after nmi vector", 32'(irq_vec), 17);
        check("R6", "swi level", 32'(irq_lvl), 6);
        check("R6", "swi hw/ld", {30'd0, irq_hw, irq_lvl_ld}, 32'h1);
        ack_once();
        tick();
        check("R5", "source reload vector", 32'(irq_vec), 8);
        check("R5", "source reload level", 32'(irq_lvl), 7);
        clear_slot();

        // Non-maskable with interrupts disabled at top level
        cpu_ie = 1'b0; cpu_lvl = 3'd7; nmi_req = 1'b1;
        tick();
        nmi_req = 1'b0;
        check("R1", "nmi ignores mask", {27'd0, irq_valid, irq_vec}, {27'd0, 1'b1, 5'd2});
        clear_slot();

        // Software request with mask closed and no level
        swi_req = 1'b1; swi_vec = 5'd30; swi_lvl_en = 1'b0;
        tick();
        swi_req = 1'b0;
        check("R6", "swi ignores mask", {27'd0, irq_valid, irq_vec}, {27'd0, 1'b1, 5'd30});
        check("R6", "swi no level load", 32'(irq_lvl_ld), 0);
        clear_slot();

        // Slot holds against a stronger late request
        cpu_ie = 1'b1; cpu_lvl = 3'd0; src_req = 8'h01;
        tick();
        src_req = 8'h81;
        repeat (3) tick();
        check("R5", "held vector", 32'(irq_vec), 4);
        check("R5", "held level", 32'(irq_lvl), 3);
        ack_once();
        tick();
        check("R5", "next after ack", 32'(irq_vec), 11);
        clear_slot();

        // Wake decisions
        cpu_asleep = 1'b1; cpu_ie = 1'b0; src_req = 8'h08;
        tick();
        check("R7", "wake on level-0 source", 32'(wake), 1);
        check("R8", "no isr on masked source", 32'(wake_isr), 0);
        src_req = '0;
        tick();
        check("R7", "no cause no wake", 32'(wake), 0);
        dbg_req = 1'b1;
        tick();
        dbg_req = 1'b0;
        check("R8", "debug wake without isr", {30'd0, wake, wake_isr}, 32'h2);
        nmi_req = 1'b1;
        tick();
        nmi_req = 1'b0;
        check("R8", "nmi wake with isr", {30'd0, wake, wake_isr}, 32'h3);
        clear_slot();
        cpu_ie = 1'b1; cpu_lvl = 3'd7; src_req = 8'h10;
        tick();
        check("R7", "wake despite level mask", {30'd0, wake, wake_isr}, 32'h2);
        cpu_lvl = 3'd0; src_req = 8'h01;
        tick();
        check("R8", "takeable source isr", {30'd0, wake, wake_isr}, 32'h3);
        clear_slot();
        cpu_asleep = 1'b0; src_req = 8'h01;
        tick();
        check("R7", "awake core no wake", 32'(wake), 0);
        clear_slot();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule